// File: doc/BRIEF.md
# Low-speed USB packet transmitter

This block turns a packet held by a byte source into low-speed USB line signalling. On a start request it takes the bus by enabling its drivers in the idle (J) state for one bit period. It then sends the sync byte and the remaining bytes least significant bit first. The bits are NRZI encoded, and a stuffed bit follows every run of six ones. The packet ends with two bit periods of SE0 and one driven J bit, after which the drivers are released. CRC and packet content come from the byte source. The block only serializes.

A handshake shortcut sends a two-byte packet made of the sync byte and an ACK or NAK PID, with no byte source involved. The bit rate comes from a divider on the system clock: with the default of 8 clocks per bit, a 12 MHz clock gives 1.5 Mbit/s. A pending device address on `new_addr` is copied to `dev_addr` only when a data packet completes. Handshake packets never commit it.

The byte source is asked for each byte with a one-cycle `src_req` pulse. It answers with `src_valid` and `src_data` before the current byte has been shifted out.

Top module: `usb_ls_tx`

## Requirements
- R1: While reset is high and after it, until a start: oe, dp_out, dm_out, done and src_req are 0 and dev_addr is 0.
- R2: A start accepted in idle drives J (oe=1, dm_out=1, dp_out=0) from the next clock edge for exactly CLKS_PER_BIT cycles before the first sync bit.
- R3: The sync byte 0x80 is always sent first, and bits go out least significant first. byte_count includes the sync byte. A data packet issues exactly byte_count-1 src_req pulses, and sends those source bytes in order.
- R4: NRZI line states are J = (dp_out=0, dm_out=1) and K = (dp_out=1, dm_out=0). A 0 bit toggles the line and a 1 bit holds it.
- R5: After six consecutive 1 bits an extra toggle is inserted, and this also applies right before end of packet. Every toggle restarts the run count.
- R6: After the last bit (and any stuffed bit), SE0 (oe=1, both lines 0) is driven for two bit periods, then J for one bit period. Then oe, dp_out and dm_out fall to 0 and done pulses high for one cycle.
- R7: A start with hs_sel=1 sends exactly the sync byte and then PID 0xD2 (hs_nak=0, ACK) or 0x5A (hs_nak=1, NAK), and issues no src_req.
- R8: dev_addr takes new_addr at the end of a data packet and keeps its value through a handshake packet.
- R9: A start pulse while a packet is in progress is ignored. The packet on the lines, src_req and done are unaffected.
- R10: Every line state lasts a whole bit period of CLKS_PER_BIT cycles, and the outputs change only at bit boundaries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a packet (taken only when idle) |
| byte_count | input | CNT_W | Bytes in a data packet, sync included |
| hs_sel | input | 1 | 1: send a handshake packet instead of source data |
| hs_nak | input | 1 | Handshake PID select: 0 ACK, 1 NAK |
| src_req | output | 1 | One-cycle request for the next source byte |
| src_valid | input | 1 | Source byte present on src_data |
| src_data | input | 8 | Source byte |
| new_addr | input | ADDR_W | Pending device address |
| dev_addr | output | ADDR_W | Committed device address |
| dp_out | output | 1 | D+ drive level |
| dm_out | output | 1 | D- drive level |
| oe | output | 1 | Line driver enable |
| done | output | 1 | One-cycle pulse when the drivers are released |

## Verification
One data packet mixes zeros, two full bytes of ones and a final byte ending in six ones. It separates plain NRZI toggling from stuffing inside a byte, stuffing across a byte boundary, and the stuff bit that must come before end of packet. ACK and NAK handshakes differ only in the PID, which shows that the PID choice is made and that the source is left alone. A sync-only data packet checks the byte count at its lower edge and commits the address without any source traffic. A start injected mid-packet must leave the expected line sequence untouched. Each bit period is sampled both at its middle and at its last cycle, which catches a wrong divider or an early edge.

// File: rtl/usb_ls_tx_pkg.sv
package usb_ls_tx_pkg;
  typedef enum logic [2:0] {
    TX_IDLE, TX_PREJ, TX_DATA, TX_SE0, TX_EOPJ
  } tx_state_e;

  typedef enum logic [2:0] {
    LC_NONE, LC_J, LC_BIT, LC_SE0, LC_OFF
  } line_cmd_e;

  localparam logic [7:0] SYNC_BYTE = 8'h80;
  localparam logic [7:0] PID_ACK   = 8'hD2;
  localparam logic [7:0] PID_NAK   = 8'h5A;
endpackage

// File: rtl/usb_ls_bit_timer.sv
module usb_ls_bit_timer #(
  parameter int CLKS_PER_BIT = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int CW = (CLKS_PER_BIT > 2) ? $clog2(CLKS_PER_BIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(CLKS_PER_BIT - 1);

  logic [CW-1:0] cnt;

  assign tick = run && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end

  // Period counter never passes its limit (R10)
  assert_cnt_range_R10: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST);
endmodule

// File: rtl/usb_ls_line_drv.sv
module usb_ls_line_drv
  import usb_ls_tx_pkg::*;
#(
  parameter int STUFF_RUN = 6
) (
  input  logic      clk,
  input  logic      rst,
  input  line_cmd_e cmd,
  input  logic      bit_in,
  output logic      dp,
  output logic      dm,
  output logic      oe,
  output logic      stuff_due
);
  localparam int RW = $clog2(STUFF_RUN + 1);

  logic [RW-1:0] ones;

  assign stuff_due = (ones == RW'(STUFF_RUN));

  always_ff @(posedge clk) begin
    if (rst) begin
      dp <= 1'b0; dm <= 1'b0; oe <= 1'b0; ones <= '0;
    end else begin
      case (cmd)
        LC_J: begin
          oe <= 1'b1; dp <= 1'b0; dm <= 1'b1; ones <= '0;
        end
        LC_BIT: begin
          if (stuff_due || !bit_in) begin
            dp <= ~dp; dm <= ~dm; ones <= '0;
          end else begin
            ones <= ones + 1'b1;
          end
        end
        LC_SE0: begin
          dp <= 1'b0; dm <= 1'b0;
        end
        LC_OFF: begin
          oe <= 1'b0; dp <= 1'b0; dm <= 1'b0; ones <= '0;
        end
        default: ;
      endcase
    end
  end

  // Without a command the lines do not move (R10)
  assert_hold_between_R10: assert property (@(posedge clk) disable iff (rst)
    (cmd == LC_NONE) |=> $stable({dp, dm, oe}));
  // A data 1 keeps the line level (R4)
  assert_one_holds_R4: assert property (@(posedge clk) disable iff (rst)
    (cmd == LC_BIT && !stuff_due && bit_in) |=> $stable({dp, dm}));
  // Data bits only go out on an enabled, differential bus (R4)
  assert_bit_driven_R4: assert property (@(posedge clk) disable iff (rst)
    (cmd == LC_BIT) |-> (oe && (dp != dm)));
  // Run of ones never exceeds the stuffing limit (R5)
  assert_run_bound_R5: assert property (@(posedge clk) disable iff (rst)
    ones <= RW'(STUFF_RUN));
endmodule

// File: rtl/usb_ls_tx.sv
module usb_ls_tx
  import usb_ls_tx_pkg::*;
#(
  parameter int CLKS_PER_BIT = 8,
  parameter int CNT_W        = 8,
  parameter int ADDR_W       = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [CNT_W-1:0]  byte_count,
  input  logic              hs_sel,
  input  logic              hs_nak,
  output logic              src_req,
  input  logic              src_valid,
  input  logic [7:0]        src_data,
  input  logic [ADDR_W-1:0] new_addr,
  output logic [ADDR_W-1:0] dev_addr,
  output logic              dp_out,
  output logic              dm_out,
  output logic              oe,
  output logic              done
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  localparam logic [CNT_W-1:0] TWO = CNT_W'(2);

  tx_state_e  state;
  line_cmd_e  cmd;
  logic       tick, stuff_due, bit_take, se0_2nd, hs_pkt, req_pend;
  logic [7:0] sh, nxt;
  logic [2:0] bidx;
  logic [CNT_W-1:0] bytes_left;

  usb_ls_bit_timer #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_timer (
    .clk(clk), .rst(rst), .run(state != TX_IDLE), .tick(tick)
  );

  usb_ls_line_drv #(.STUFF_RUN(6)) u_line (
    .clk(clk), .rst(rst), .cmd(cmd), .bit_in(sh[0]),
    .dp(dp_out), .dm(dm_out), .oe(oe), .stuff_due(stuff_due)
  );

  always_comb begin
    cmd      = LC_NONE;
    bit_take = 1'b0;
    case (state)
      TX_IDLE: if (start) cmd = LC_J;
      TX_PREJ, TX_DATA: if (tick) begin
        if (stuff_due) cmd = LC_BIT;
        else if (bytes_left != '0) begin
          cmd = LC_BIT; bit_take = 1'b1;
        end else cmd = LC_SE0;
      end
      TX_SE0:  if (tick && se0_2nd) cmd = LC_J;
      TX_EOPJ: if (tick) cmd = LC_OFF;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= TX_IDLE; sh <= '0; nxt <= '0; bidx <= '0;
      bytes_left <= '0; se0_2nd <= 1'b0; hs_pkt <= 1'b0;
      req_pend <= 1'b0; src_req <= 1'b0; done <= 1'b0; dev_addr <= '0;
    end else begin
      src_req <= 1'b0;
      done    <= 1'b0;
      if (src_valid) begin
        nxt <= src_data; req_pend <= 1'b0;
      end
      case (state)
        TX_IDLE: if (start) begin
          state   <= TX_PREJ;
          sh      <= SYNC_BYTE;
          bidx    <= '0;
          se0_2nd <= 1'b0;
          hs_pkt  <= hs_sel;
          if (hs_sel) begin
            bytes_left <= TWO;
            nxt        <= hs_nak ? PID_NAK : PID_ACK;
          end else begin
            bytes_left <= (byte_count == '0) ? ONE : byte_count;
            if (byte_count > ONE) begin
              src_req <= 1'b1; req_pend <= 1'b1;
            end
          end
        end
        TX_PREJ: if (tick) state <= TX_DATA;
        TX_DATA: if (cmd == LC_SE0) state <= TX_SE0;
        TX_SE0: if (tick) begin
          if (se0_2nd) state <= TX_EOPJ;
          else se0_2nd <= 1'b1;
        end
        TX_EOPJ: if (tick) begin
          state <= TX_IDLE;
          done  <= 1'b1;
          if (!hs_pkt) dev_addr <= new_addr;
        end
        default: state <= TX_IDLE;
      endcase
      if (bit_take) begin
        if (bidx == 3'd7) begin
          bidx       <= '0;
          bytes_left <= bytes_left - 1'b1;
          if (bytes_left > ONE) begin
            sh <= nxt;
            if (!hs_pkt && bytes_left > TWO) begin
              src_req <= 1'b1; req_pend <= 1'b1;
            end
          end
        end else begin
          bidx <= bidx + 1'b1;
          sh   <= {1'b0, sh[7:1]};
        end
      end
    end
  end

  // SE0 appears on an enabled bus only in the end-of-packet state (R6)
  assert_se0_in_eop_R6: assert property (@(posedge clk) disable iff (rst)
    (oe && !dp_out && !dm_out) |-> (state == TX_SE0));
  // done coincides with released drivers (R6)
  assert_done_released_R6: assert property (@(posedge clk) disable iff (rst)
    done |-> (!oe && !dp_out && !dm_out));
  // Handshake packets never ask the source (R7)
  assert_hs_no_req_R7: assert property (@(posedge clk) disable iff (rst)
    (hs_pkt && state != TX_IDLE) |-> !src_req);
  // Source data only answers an open request (R3)
  assert_valid_requested_R3: assert property (@(posedge clk) disable iff (rst)
    src_valid |-> req_pend);
  // Address moves only at the end of a data packet (R8)
  assert_addr_commit_R8: assert property (@(posedge clk) disable iff (rst)
    !$stable(dev_addr) |-> (done && !hs_pkt));
  // A start while busy does not restart the sequence (R9)
  assert_busy_start_R9: assert property (@(posedge clk) disable iff (rst)
    (state != TX_IDLE && start) |=> (state != TX_PREJ || $past(state) == TX_PREJ));
endmodule

// File: tb/sim_usb_ls_tx.sv
module sim_usb_ls_tx;
  localparam int CPB = 8;
  localparam logic [2:0] SJ = 3'b101, SK = 3'b110, SS = 3'b100, SO = 3'b000;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0, hs_sel = 1'b0, hs_nak = 1'b0;
  logic [7:0] byte_count = '0, src_data = '0;
  logic src_valid = 1'b0, src_req, dp_out, dm_out, oe, done;
  logic [6:0] new_addr = '0, dev_addr;

  int checks = 0, errors = 0, req_cnt = 0, done_cnt = 0;
  bit finished = 0;
  logic [2:0] exp_q[$];
  string tag_q[$];
  logic [7:0] src_q[$];
  event go;

  always #2 clk = ~clk;

  usb_ls_tx #(.CLKS_PER_BIT(CPB), .CNT_W(8), .ADDR_W(7)) u0 (
    .clk(clk), .rst(rst), .start(start), .byte_count(byte_count),
    .hs_sel(hs_sel), .hs_nak(hs_nak), .src_req(src_req),
    .src_valid(src_valid), .src_data(src_data), .new_addr(new_addr),
    .dev_addr(dev_addr), .dp_out(dp_out), .dm_out(dm_out), .oe(oe), .done(done)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Byte source: answers each request on the next edge
  always @(negedge clk) begin
    if (src_req && src_q.size() > 0) begin
      src_valid <= 1'b1; src_data <= src_q.pop_front(); req_cnt++;
    end else if (src_req) begin
      src_valid <= 1'b1; src_data <= 8'h00; req_cnt++;
    end else src_valid <= 1'b0;
  end

  always @(posedge clk) if (done) done_cnt++;

  // Monitor: pops expected line states, samples each bit mid and last cycle
  initial begin
    forever begin
      @(go);
      while (exp_q.size() > 0) begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        check({oe, dp_out, dm_out} == exp_q[0], tag_q[0], {oe, dp_out, dm_out}, exp_q[0]);
        repeat (3) @(posedge clk);
        @(negedge clk);
        check({oe, dp_out, dm_out} == exp_q[0], "R10 late", {oe, dp_out, dm_out}, exp_q[0]);
        @(posedge clk);
        void'(exp_q.pop_front());
        void'(tag_q.pop_front());
      end
    end
  end

  task automatic push(input logic [2:0] s, input string t);
    exp_q.push_back(s); tag_q.push_back(t);
  endtask

  // Driver: builds the expected line sequence, then starts the packet
  task automatic send_pkt(input bit hs, input bit nak, input int cnt,
                          input string tag, input bit poke);
    logic [7:0] bytes[$];
    bit lvl = 0;
    int ones = 0, d0, r0;
    bytes.push_back(8'h80);
    if (hs) bytes.push_back(nak ? 8'h5A : 8'hD2);
    else for (int i = 0; i < cnt - 1; i++) bytes.push_back(src_q[i]);
    push(SJ, "R2 pre-sync J");
    foreach (bytes[b]) for (int k = 0; k < 8; k++) begin
      if (!bytes[b][k]) begin lvl = ~lvl; ones = 0; end
      else ones++;
      push(lvl ? SK : SJ, tag);
      if (ones == 6) begin lvl = ~lvl; ones = 0; push(lvl ? SK : SJ, "R5 stuff"); end
    end
    push(SS, "R6 SE0 1"); push(SS, "R6 SE0 2"); push(SJ, "R6 EOP J"); push(SO, "R6 release");
    d0 = done_cnt; r0 = req_cnt;
    @(negedge clk);
    start = 1'b1; hs_sel = hs; hs_nak = nak; byte_count = 8'(cnt);
    @(posedge clk);
    -> go;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      repeat (20) @(negedge clk);
      start = 1'b1; hs_sel = 1'b0; byte_count = 8'd3;
      @(negedge clk);
      start = 1'b0;
    end
    wait (exp_q.size() == 0);
    repeat (2) @(negedge clk);
    check(done_cnt == d0 + 1, poke ? "R9 done count" : "R6 done pulse", done_cnt - d0, 1);
    check(req_cnt - r0 == (hs ? 0 : cnt - 1), hs ? "R7 no requests" : "R3 request count",
          req_cnt - r0, hs ? 0 : cnt - 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check({oe, dp_out, dm_out, done, src_req} == 5'b0, "R1 reset lines",
          {oe, dp_out, dm_out, done, src_req}, 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    check({oe, dp_out, dm_out, done, src_req} == 5'b0, "R1 idle lines",
          {oe, dp_out, dm_out, done, src_req}, 0);
    check(dev_addr == 7'h00, "R1 dev_addr", dev_addr, 0);

    // Data packet: zeros, two bytes of ones, tail with six ones
    new_addr = 7'h15;
    src_q = '{8'h2D, 8'hFF, 8'hFF, 8'h01, 8'hFC};
    send_pkt(0, 0, 6, "R4 data", 0);
    check(dev_addr == 7'h15, "R8 commit after data", dev_addr, 7'h15);

    new_addr = 7'h2A;
    send_pkt(1, 0, 0, "R7 ACK", 0);
    check(dev_addr == 7'h15, "R8 held after ACK", dev_addr, 7'h15);
    send_pkt(1, 1, 0, "R7 NAK", 1);
    check(dev_addr == 7'h15, "R8 held after NAK", dev_addr, 7'h15);

    // Sync-only data packet
    send_pkt(0, 0, 1, "R3 sync only", 0);
    check(dev_addr == 7'h2A, "R8 commit sync-only", dev_addr, 7'h2A);

    // Plain data with alternating bits, start poked mid-packet
    src_q = '{8'h55, 8'hAA};
    send_pkt(0, 0, 3, "R3 data order", 1);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule